// File: doc/BRIEF.md
# Event-Driven Timestamp Counter

This block keeps a 32-bit time count that follows a stream of decoded link event codes. Each clock cycle it may receive one 8-bit event code, qualified by a valid strobe, and a carrier tick strobe. One programmable code is the synchronisation code. When it arrives, the count returns to zero. The count advances from one of two sources. The first source is a second programmable code. The second is a slow tick that the block makes by dividing the carrier ticks by ten.

A single-cycle trigger input copies the running count into a capture register. Software can read that register until the next trigger replaces it. A capture and a sync event each set their own sticky flag. Software clears a flag by writing 1 to it. The interrupt request is high while either flag is set. A small word-addressed register port holds the configuration and gives the count, the capture and the flags back to software.

Top module: `evt_timestamp`

## Requirements
- R1: After reset, the config word, the running count, the capture register and both flags read as zero.
- R2: Address 0 is the configuration word. Bits [7:0] hold the sync code and bits [15:8] hold the advance code. Bit 16 selects the advance source: 0 means the advance code, 1 means the divided tick. Writing address 0 stores the word, and the same fields read back.
- R3: In event mode, each accepted event that carries the advance code raises the count (read at address 1) by one. The new value is visible from the cycle after the event.
- R4: A code that is neither the sync code nor the selected source never changes the count. In tick mode, the advance code has no effect on the count.
- R5: In tick mode, the count rises by one on every tenth carrier tick strobe. Carrier strobes have no effect in event mode.
- R6: An accepted sync code clears both the count and the tick divider. After a sync, the count needs a full ten carrier ticks before it advances again.
- R7: If a sync and an advance fall in the same cycle, the count becomes zero.
- R8: A trigger pulse copies into the capture register (address 2) the count that was held before that clock edge. The captured value stays unchanged until the next trigger.
- R9: Address 3 holds the flags: bit 0 is set by a capture and bit 1 by a sync. Each flag stays set until it is cleared. The interrupt output equals the OR of the two flags.
- R10: Writing address 3 clears each flag whose written bit is 1 and leaves flags whose written bit is 0 unchanged. When a new set and a clear fall in the same cycle, the set wins.
- R11: An event code with the valid strobe low has no effect on the count or the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_valid | input | 1 | Event code strobe |
| ev_code | input | 8 | Decoded event code |
| carrier_tick | input | 1 | One strobe per link carrier period |
| stamp_trig | input | 1 | Capture trigger pulse |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt request, high while a flag is set |

## Verification
The bench builds the block with its default parameters: a 32-bit count, 8-bit codes and a divide ratio of ten. With these values the whole divider cycle fits in a short run. Because the divide ratio is ten, the bench can test the tick boundary exactly: after nine strobes the count has not moved, and on the tenth it has. It also tests a sync that falls on the same cycle as the tenth strobe, and a sync that falls on the same cycle as a trigger, which shows that the capture takes the value from before the clear.

// File: rtl/evt_timestamp.sv
module evt_timestamp #(
  parameter int CW  = 32,
  parameter int EW  = 8,
  parameter int DIV = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_valid,
  input  logic [EW-1:0] ev_code,
  input  logic          carrier_tick,
  input  logic          stamp_trig,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [CW-1:0] reg_wdata,
  output logic [CW-1:0] reg_rdata,
  output logic          irq
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int FW = 2*EW + 1;

  logic [EW-1:0] sync_code, adv_code;
  logic          use_tick;
  logic [DW-1:0] div;
  logic [CW-1:0] cnt, cap;
  logic          f_cap, f_sync;

  wire sync_hit = ev_valid && (ev_code == sync_code);
  wire adv_hit  = ev_valid && (ev_code == adv_code);
  wire div_wrap = carrier_tick && (div == DW'(DIV-1));
  wire advance  = use_tick ? div_wrap : adv_hit;
  wire cfg_wr   = reg_wr && (reg_addr == 2'd0);
  wire flg_wr   = reg_wr && (reg_addr == 2'd3);
  wire unused_wdata = ^reg_wdata[CW-1:FW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_code <= '0;
      adv_code  <= '0;
      use_tick  <= 1'b0;
    end else if (cfg_wr) begin
      sync_code <= reg_wdata[EW-1:0];
      adv_code  <= reg_wdata[2*EW-1:EW];
      use_tick  <= reg_wdata[2*EW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sync_hit) div <= '0;
    else if (carrier_tick)  div <= div_wrap ? '0 : div + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || sync_hit) cnt <= '0;
    else if (advance)       cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)          cap <= '0;
    else if (stamp_trig) cap <= cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      f_cap  <= 1'b0;
      f_sync <= 1'b0;
    end else begin
      f_cap  <= stamp_trig || (f_cap  && !(flg_wr && reg_wdata[0]));
      f_sync <= sync_hit   || (f_sync && !(flg_wr && reg_wdata[1]));
    end
  end

  assign irq = f_cap | f_sync;

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = CW'({use_tick, adv_code, sync_code});
      2'd1:    reg_rdata = cnt;
      2'd2:    reg_rdata = cap;
      default: reg_rdata = CW'({f_sync, f_cap});
    endcase
  end

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && ev_code == sync_code) |=> (cnt == '0)); // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !(ev_valid && ev_code == sync_code) |=> (cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)); // R3
  AST_NO_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_valid && !carrier_tick) |=> $stable(cnt)); // R11
  AST_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    stamp_trig |=> (cap == $past(cnt))); // R8
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !stamp_trig |=> $stable(cap)); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (f_cap && !(reg_wr && reg_addr == 2'd3 && reg_wdata[0])) |=> f_cap); // R9
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    div < DW'(DIV)); // R5
endmodule

// File: tb/sim_evt_timestamp.sv
module sim_evt_timestamp;
  localparam int PER = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_valid = 1'b0, carrier_tick = 1'b0, stamp_trig = 1'b0, reg_wr = 1'b0;
  logic [7:0] ev_code = '0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq;
  int total = 0, bad = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #(PER/2) clk = ~clk;

  evt_timestamp u0 (.clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_code(ev_code),
    .carrier_tick(carrier_tick), .stamp_trig(stamp_trig), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (reg_rdata !== e) begin
        bad++;
        $display("FAIL %s addr=%0d actual=%h expected=%h", t, reg_addr, reg_rdata, e);
      end
    end
  end

  task automatic expect_rd(input logic [1:0] a, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic expect_irq(input logic e, input string t);
    @(negedge clk);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic ev(input logic [7:0] c, input logic v, input logic tk, input logic tr);
    @(posedge clk); #1;
    ev_valid = v; ev_code = c; carrier_tick = tk; stamp_trig = tr;
    @(posedge clk); #1;
    ev_valid = 1'b0; carrier_tick = 1'b0; stamp_trig = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) ev(8'h00, 1'b0, 1'b1, 1'b0);
  endtask

  initial begin
    #(PER*100000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    expect_rd(2'd0, 32'h0, "R1 config");
    expect_rd(2'd1, 32'h0, "R1 count");
    expect_rd(2'd2, 32'h0, "R1 capture");
    expect_rd(2'd3, 32'h0, "R1 flags");
    wr(2'd0, 32'h0000_2155);
    expect_rd(2'd0, 32'h0000_2155, "R2 readback");
    for (int i = 0; i < 5; i++) ev(8'h21, 1'b1, 1'b0, 1'b0);
    expect_rd(2'd1, 32'd5, "R3 five advances");
    ev(8'h30, 1'b1, 1'b0, 1'b0);
    ticks(12);
    expect_rd(2'd1, 32'd5, "R4 other code and carrier in event mode");
    ev(8'h21, 1'b0, 1'b0, 1'b0);
    ev(8'h55, 1'b0, 1'b0, 1'b0);
    expect_rd(2'd1, 32'd5, "R11 strobe low");
    expect_rd(2'd3, 32'd0, "R11 no sync flag");
    ev(8'h00, 1'b0, 1'b0, 1'b1);
    expect_rd(2'd2, 32'd5, "R8 capture");
    expect_rd(2'd3, 32'd1, "R9 capture flag");
    expect_irq(1'b1, "R9 irq");
    ev(8'h21, 1'b1, 1'b0, 1'b0);
    ev(8'h21, 1'b1, 1'b0, 1'b0);
    expect_rd(2'd1, 32'd7, "R3 continue");
    expect_rd(2'd2, 32'd5, "R8 capture held");
    ev(8'h55, 1'b1, 1'b0, 1'b0);
    expect_rd(2'd1, 32'd0, "R6 sync clears");
    expect_rd(2'd3, 32'd3, "R9 sync flag");
    wr(2'd3, 32'd1);
    expect_rd(2'd3, 32'd2, "R10 clear capture flag only");
    wr(2'd3, 32'd2);
    expect_rd(2'd3, 32'd0, "R10 clear sync flag");
    expect_irq(1'b0, "R9 irq low");
    wr(2'd0, 32'h0001_2155);
    expect_rd(2'd0, 32'h0001_2155, "R2 tick select");
    ev(8'h55, 1'b1, 1'b0, 1'b0);
    ticks(9);
    expect_rd(2'd1, 32'd0, "R5 nine ticks");
    ticks(1);
    expect_rd(2'd1, 32'd1, "R5 tenth tick");
    ev(8'h21, 1'b1, 1'b0, 1'b0);
    expect_rd(2'd1, 32'd1, "R4 advance code ignored in tick mode");
    ticks(20);
    expect_rd(2'd1, 32'd3, "R5 thirty ticks");
    ticks(9);
    ev(8'h55, 1'b1, 1'b1, 1'b1);
    expect_rd(2'd1, 32'd0, "R7 sync beats advance");
    expect_rd(2'd2, 32'd3, "R8 capture before clear");
    ticks(9);
    expect_rd(2'd1, 32'd0, "R6 divider cleared");
    ticks(1);
    expect_rd(2'd1, 32'd1, "R6 divider restarts");
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = 2'd3; reg_wdata = 32'd3; stamp_trig = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0; stamp_trig = 1'b0;
    expect_rd(2'd3, 32'd1, "R10 set beats clear");
    expect_rd(2'd2, 32'd1, "R8 second capture");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule